// File: doc/BRIEF.md
# MESI L1 Coherence Agent

This block is the coherence controller for one processor's private write-back L1 cache. The cache is fully associative. Each way holds a tag, one data word and a MESI state: Invalid, Shared, Exclusive or Modified. The processor issues one load or store at a time. When the request hits with enough permission, the agent answers locally. Otherwise it sends a read, upgrade or writeback message to a central directory and stalls the processor until the matching grant arrives.

The directory can send an invalidating snoop on any cycle, including while the agent is stalled on its own request. The agent answers every snoop on the next cycle. The kind of answer depends on the state the snooped line held. Data leaves the cache only as a writeback: either when a Modified victim is evicted or when a Modified line is snooped. Victims are chosen by preferring any Invalid way and otherwise taking the least recently used way.

Messages travel on two single-cycle valid/type/address/data channels, with no flow control. The outgoing codes are: 1 read-shared, 2 read-exclusive, 3 upgrade, 4 invalidate-ack, 5 clean invalidate-ack, 6 writeback. The incoming codes are: 1 fill-shared, 2 fill-exclusive, 3 upgrade-granted, 4 invalidate, 5 writeback-done. Every outgoing message, and every processor response, is registered and appears one cycle after the event that caused it.

Top module: `mesi_l1_agent`

## Requirements
- R1: After reset all ways are Invalid, `cpu_req_ready` is 1, and neither `msg_out_valid` nor `cpu_resp_valid` is asserted.
- R2: On a miss, an Invalid way is always chosen as the victim before any valid way. Reusing it sends no writeback and no other message besides the read.
- R3: A load miss sends read-shared (out code 1) for the load address. On fill-shared (in code 1) the line becomes Shared, and the load responds with the fill data. A later load hit responds with the stored data and sends no message.
- R4: A store miss sends read-exclusive (out code 2). On fill-exclusive (in code 2) the line is installed with the store data in Modified, and the store responds with its write data.
- R5: A store that hits a Shared line sends upgrade (out code 3) and keeps `cpu_req_ready` low until upgrade-granted (in code 3) arrives. Then the write commits, the line becomes Modified, and the store responds.
- R6: A store that hits an Exclusive line (a load answered with fill-exclusive) writes it and makes it Modified, with no outgoing message.
- R7: An invalidate (in code 4) to an Exclusive line is answered with clean invalidate-ack (out code 5) and no data, and the line becomes Invalid.
- R8: An invalidate to a Modified line is answered with writeback (out code 6) carrying the line's data, and the line becomes Invalid.
- R9: An invalidate to a Shared line is answered with invalidate-ack (out code 4). An invalidate to an address not present is answered with clean invalidate-ack (out code 5). A load of an invalidated line misses again.
- R10: Only one processor request is outstanding at a time, so `cpu_req_ready` is low while a miss is pending. Invalidates that arrive during that wait are still answered one cycle later.
- R11: When the victim is Modified, the agent first sends writeback (out code 6) with the victim's address and data. It then waits for writeback-done (in code 5) before it sends the read for the new address.
- R12: When every way is valid, the victim is the way least recently touched by a hit or an install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Request address (whole address is the tag) |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Agent accepts a request this cycle |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_data | output | DATA_W | Load data, or the written data for a store |
| msg_out_valid | output | 1 | Outgoing directory message present |
| msg_out_type | output | 3 | Outgoing message code |
| msg_out_addr | output | ADDR_W | Outgoing message address |
| msg_out_data | output | DATA_W | Writeback data, otherwise zero |
| msg_in_valid | input | 1 | Incoming directory message present |
| msg_in_type | input | 3 | Incoming message code |
| msg_in_addr | input | ADDR_W | Incoming message address |
| msg_in_data | input | DATA_W | Fill data |

## Verification
The bench sends an invalidate while a load miss is still waiting for its fill. A design that ignored snoops during a stall would leave the directory without an answer, and a design that mixed up the two paths would write back the wrong line. Clean and dirty snoops are told apart: answering an Exclusive line with a writeback, or a Modified line without its data, shows up directly at the message port. The bench also fills every way and then touches ways in a chosen order. This exposes a victim picker that ignores recency, evicts a Modified line silently, or issues the new read before writeback-done arrives. It also checks that the silent Exclusive-to-Modified store produces no stray upgrade message.

// File: rtl/mesi_l1_agent.sv
module mesi_l1_agent #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_data,
  output logic              msg_out_valid,
  output logic [2:0]        msg_out_type,
  output logic [ADDR_W-1:0] msg_out_addr,
  output logic [DATA_W-1:0] msg_out_data,
  input  logic              msg_in_valid,
  input  logic [2:0]        msg_in_type,
  input  logic [ADDR_W-1:0] msg_in_addr,
  input  logic [DATA_W-1:0] msg_in_data
);
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

  localparam logic [1:0] LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3;

  localparam logic [2:0] O_RD_SH = 3'd1, O_RD_EX = 3'd2, O_UPGR = 3'd3,
                         O_INV_ACK = 3'd4, O_INV_CLEAN = 3'd5, O_WBACK = 3'd6;
  localparam logic [2:0] I_FILL_SH = 3'd1, I_FILL_EX = 3'd2, I_UPGR_OK = 3'd3,
                         I_INVAL = 3'd4, I_WB_DONE = 3'd5;

  typedef enum logic [1:0] {IDLE, WAIT_WB, WAIT_FILL, WAIT_UPGR} fsm_t;
  fsm_t fsm;

  logic [1:0]        st  [WAYS];
  logic [ADDR_W-1:0] tag [WAYS];
  logic [DATA_W-1:0] dat [WAYS];
  logic [WW-1:0]     age [WAYS];

  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [WW-1:0]     r_way;

  logic          c_hit, s_hit, inv_found;
  logic [WW-1:0] c_way, s_way, inv_way, lru_way, victim, touch_way;

  always_comb begin
    c_hit = 1'b0; c_way = '0;
    s_hit = 1'b0; s_way = '0;
    inv_found = 1'b0; inv_way = '0; lru_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (st[i] != LS_I && tag[i] == cpu_req_addr) begin c_hit = 1'b1; c_way = WW'(i); end
      if (st[i] != LS_I && tag[i] == msg_in_addr)  begin s_hit = 1'b1; s_way = WW'(i); end
      if (st[i] == LS_I) begin inv_found = 1'b1; inv_way = WW'(i); end
      if (age[i] == WW'(WAYS - 1)) lru_way = WW'(i);
    end
  end

  wire snoop_in  = msg_in_valid && msg_in_type == I_INVAL;
  wire accept    = cpu_req_valid && cpu_req_ready;
  wire fill_in   = fsm == WAIT_FILL && msg_in_valid && msg_in_addr == r_addr &&
                   (msg_in_type == I_FILL_SH || msg_in_type == I_FILL_EX);
  wire upgr_in   = fsm == WAIT_UPGR && msg_in_valid && msg_in_type == I_UPGR_OK;
  wire wbdone_in = fsm == WAIT_WB && msg_in_valid && msg_in_type == I_WB_DONE;
  wire touch_en  = (accept && c_hit) || fill_in || upgr_in;

  assign victim        = inv_found ? inv_way : lru_way;
  assign touch_way     = accept ? c_way : r_way;
  assign cpu_req_ready = fsm == IDLE && !snoop_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm <= IDLE;
      for (int i = 0; i < WAYS; i++) begin
        st[i] <= LS_I; tag[i] <= '0; dat[i] <= '0; age[i] <= WW'(i);
      end
      r_we <= 1'b0; r_addr <= '0; r_wdata <= '0; r_way <= '0;
      cpu_resp_valid <= 1'b0; cpu_resp_data <= '0;
      msg_out_valid <= 1'b0; msg_out_type <= '0; msg_out_addr <= '0; msg_out_data <= '0;
    end else begin
      msg_out_valid  <= 1'b0;
      cpu_resp_valid <= 1'b0;
      if (touch_en)
        for (int i = 0; i < WAYS; i++)
          if (WW'(i) == touch_way) age[i] <= '0;
          else if (age[i] < age[touch_way]) age[i] <= age[i] + 1'b1;

      if (snoop_in) begin
        msg_out_valid <= 1'b1;
        msg_out_addr  <= msg_in_addr;
        msg_out_data  <= '0;
        msg_out_type  <= O_INV_CLEAN;
        if (s_hit) begin
          st[s_way] <= LS_I;
          if (st[s_way] == LS_M) begin
            msg_out_type <= O_WBACK;
            msg_out_data <= dat[s_way];
          end else if (st[s_way] == LS_S) msg_out_type <= O_INV_ACK;
        end
      end

      case (fsm)
        IDLE: if (accept) begin
          r_we <= cpu_req_we; r_addr <= cpu_req_addr; r_wdata <= cpu_req_wdata;
          if (c_hit) begin
            r_way <= c_way;
            if (!cpu_req_we) begin
              cpu_resp_valid <= 1'b1; cpu_resp_data <= dat[c_way];
            end else if (st[c_way] == LS_S) begin
              msg_out_valid <= 1'b1; msg_out_type <= O_UPGR;
              msg_out_addr <= cpu_req_addr; msg_out_data <= '0;
              fsm <= WAIT_UPGR;
            end else begin
              dat[c_way] <= cpu_req_wdata; st[c_way] <= LS_M;
              cpu_resp_valid <= 1'b1; cpu_resp_data <= cpu_req_wdata;
            end
          end else begin
            r_way <= victim;
            st[victim] <= LS_I;
            msg_out_valid <= 1'b1;
            if (st[victim] == LS_M) begin
              msg_out_type <= O_WBACK; msg_out_addr <= tag[victim];
              msg_out_data <= dat[victim];
              fsm <= WAIT_WB;
            end else begin
              msg_out_type <= cpu_req_we ? O_RD_EX : O_RD_SH;
              msg_out_addr <= cpu_req_addr; msg_out_data <= '0;
              fsm <= WAIT_FILL;
            end
          end
        end
        WAIT_WB: if (wbdone_in) begin
          msg_out_valid <= 1'b1; msg_out_type <= r_we ? O_RD_EX : O_RD_SH;
          msg_out_addr <= r_addr; msg_out_data <= '0;
          fsm <= WAIT_FILL;
        end
        WAIT_FILL: if (fill_in) begin
          tag[r_way] <= r_addr;
          cpu_resp_valid <= 1'b1;
          if (r_we) begin
            dat[r_way] <= r_wdata; st[r_way] <= LS_M; cpu_resp_data <= r_wdata;
          end else begin
            dat[r_way] <= msg_in_data; cpu_resp_data <= msg_in_data;
            st[r_way] <= (msg_in_type == I_FILL_EX) ? LS_E : LS_S;
          end
          fsm <= IDLE;
        end
        WAIT_UPGR: if (upgr_in) begin
          tag[r_way] <= r_addr; dat[r_way] <= r_wdata; st[r_way] <= LS_M;
          cpu_resp_valid <= 1'b1; cpu_resp_data <= r_wdata;
          fsm <= IDLE;
        end
        default: fsm <= IDLE;
      endcase
    end
  end
endmodule

module mesi_l1_agent_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              msg_out_valid,
  input logic [2:0]        msg_out_type,
  input logic [ADDR_W-1:0] msg_out_addr,
  input logic              msg_in_valid,
  input logic [2:0]        msg_in_type,
  input logic [ADDR_W-1:0] msg_in_addr
);
  a_r8_snoop_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_in_valid && msg_in_type == 3'd4) |=>
      (msg_out_valid && msg_out_addr == $past(msg_in_addr) &&
       (msg_out_type == 3'd4 || msg_out_type == 3'd5 || msg_out_type == 3'd6)));

  a_r5_upgrade_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_type == 3'd3) |-> !cpu_req_ready);

  a_r3_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> $past((cpu_req_valid && cpu_req_ready) ||
                             (msg_in_valid && (msg_in_type == 3'd1 ||
                              msg_in_type == 3'd2 || msg_in_type == 3'd3))));

  a_r10_msg_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid |-> $past(msg_in_valid || (cpu_req_valid && cpu_req_ready)));
endmodule

bind mesi_l1_agent mesi_l1_agent_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_resp_valid(cpu_resp_valid), .msg_out_valid(msg_out_valid),
  .msg_out_type(msg_out_type), .msg_out_addr(msg_out_addr),
  .msg_in_valid(msg_in_valid), .msg_in_type(msg_in_type), .msg_in_addr(msg_in_addr));

// File: tb/sim_mesi_l1_agent.sv
module sim_mesi_l1_agent;
  logic clk = 0, rst_n = 0;
  logic cpu_req_valid = 0, cpu_req_we = 0;
  logic [7:0] cpu_req_addr = 0;
  logic [15:0] cpu_req_wdata = 0;
  logic cpu_req_ready, cpu_resp_valid, msg_out_valid;
  logic [15:0] cpu_resp_data, msg_out_data;
  logic [2:0] msg_out_type;
  logic [7:0] msg_out_addr;
  logic msg_in_valid = 0;
  logic [2:0] msg_in_type = 0;
  logic [7:0] msg_in_addr = 0;
  logic [15:0] msg_in_data = 0;

  int checks = 0, fails = 0;
  logic [26:0] exp_msg[$];
  string       exp_msg_req[$];
  logic [15:0] exp_rsp[$];
  string       exp_rsp_req[$];

  always #5 clk = ~clk;

  mesi_l1_agent u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic want_msg(input string req, input logic [2:0] t, input logic [7:0] a, input logic [15:0] d);
    exp_msg.push_back({t, a, d}); exp_msg_req.push_back(req);
  endtask

  task automatic want_rsp(input string req, input logic [15:0] d);
    exp_rsp.push_back(d); exp_rsp_req.push_back(req);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (msg_out_valid) begin
      if (exp_msg.size() == 0) chk(0, "unexpected message", {5'd0, msg_out_type, msg_out_addr, msg_out_data}, 0);
      else begin
        logic [26:0] e; string r;
        e = exp_msg.pop_front(); r = exp_msg_req.pop_front();
        chk({msg_out_type, msg_out_addr, msg_out_data} == e, r,
            {5'd0, msg_out_type, msg_out_addr, msg_out_data}, {5'd0, e});
      end
    end
    if (cpu_resp_valid) begin
      if (exp_rsp.size() == 0) chk(0, "unexpected response", {16'd0, cpu_resp_data}, 0);
      else begin
        logic [15:0] e; string r;
        e = exp_rsp.pop_front(); r = exp_rsp_req.pop_front();
        chk(cpu_resp_data == e, r, {16'd0, cpu_resp_data}, {16'd0, e});
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic dir(input logic [2:0] t, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    msg_in_valid = 1; msg_in_type = t; msg_in_addr = a; msg_in_data = d;
    @(negedge clk);
    msg_in_valid = 0;
  endtask

  task automatic gap(); repeat (3) @(negedge clk); endtask

  task automatic load_miss(input string req, input logic [7:0] a, input logic [15:0] d);
    want_msg(req, 3'd1, a, 16'd0); want_rsp(req, d);
    cpu_op(0, a, 0); dir(3'd1, a, d); gap();
  endtask

  task automatic load_hit(input string req, input logic [7:0] a, input logic [15:0] d);
    want_rsp(req, d); cpu_op(0, a, 0); gap();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_req_ready == 1, "R1 ready", {31'd0, cpu_req_ready}, 1);
    chk(msg_out_valid == 0 && cpu_resp_valid == 0, "R1 quiet", {30'd0, msg_out_valid, cpu_resp_valid}, 0);

    // R3 load miss then hit; R2 invalid way used silently
    load_miss("R3 load miss", 8'h10, 16'h1111);
    load_hit("R3 load hit", 8'h10, 16'h1111);

    // R5 store to Shared line
    want_msg("R5 upgrade", 3'd3, 8'h10, 0); want_rsp("R5 store done", 16'hA5A5);
    cpu_op(1, 8'h10, 16'hA5A5);
    @(negedge clk);
    chk(cpu_req_ready == 0, "R5 stall", {31'd0, cpu_req_ready}, 0);
    dir(3'd3, 8'h10, 0); gap();
    load_hit("R5 data", 8'h10, 16'hA5A5);

    // R4 store miss, R8 dirty snoop
    want_msg("R4 read excl", 3'd2, 8'h20, 0); want_rsp("R4 store", 16'hB0B0);
    cpu_op(1, 8'h20, 16'hB0B0); dir(3'd2, 8'h20, 16'h2222); gap();
    want_msg("R8 writeback", 3'd6, 8'h20, 16'hB0B0);
    dir(3'd4, 8'h20, 0); gap();

    // R6 silent E->M, then dirty snoop
    want_msg("R6 read", 3'd1, 8'h30, 0); want_rsp("R6 load", 16'h3333);
    cpu_op(0, 8'h30, 0); dir(3'd2, 8'h30, 16'h3333); gap();
    want_rsp("R6 store silent", 16'hC3C3); cpu_op(1, 8'h30, 16'hC3C3); gap();
    want_msg("R6 now modified", 3'd6, 8'h30, 16'hC3C3);
    dir(3'd4, 8'h30, 0); gap();

    // R7 clean snoop of Exclusive
    want_msg("R7 read", 3'd1, 8'h40, 0); want_rsp("R7 load", 16'h4444);
    cpu_op(0, 8'h40, 0); dir(3'd2, 8'h40, 16'h4444); gap();
    want_msg("R7 clean ack", 3'd5, 8'h40, 0);
    dir(3'd4, 8'h40, 0); gap();

    // R9 Shared snoop, absent snoop, re-miss
    load_miss("R9 fill", 8'h50, 16'h5555);
    want_msg("R9 shared ack", 3'd4, 8'h50, 0); dir(3'd4, 8'h50, 0); gap();
    want_msg("R9 absent ack", 3'd5, 8'hEE, 0); dir(3'd4, 8'hEE, 0); gap();
    load_miss("R9 re-miss", 8'h50, 16'h5656);
    want_msg("R9 shared ack", 3'd4, 8'h50, 0); dir(3'd4, 8'h50, 0); gap();

    // R10 snoop while a miss is pending
    want_msg("R10 read", 3'd1, 8'h60, 0);
    cpu_op(0, 8'h60, 0);
    @(negedge clk);
    chk(cpu_req_ready == 0, "R10 busy", {31'd0, cpu_req_ready}, 0);
    want_msg("R10 snoop during wait", 3'd6, 8'h10, 16'hA5A5);
    dir(3'd4, 8'h10, 0);
    want_rsp("R10 fill after snoop", 16'h6666);
    dir(3'd1, 8'h60, 16'h6666); gap();

    // R2 fill remaining Invalid ways silently, then R12 LRU
    load_miss("R2 fill way", 8'h70, 16'h7777);
    load_miss("R2 fill way", 8'h80, 16'h8888);
    load_miss("R2 fill way", 8'h90, 16'h9999);
    load_hit("R12 touch", 8'h60, 16'h6666);
    load_miss("R12 evict oldest clean", 8'hA0, 16'hAAAA);
    want_msg("R12 upgrade", 3'd3, 8'h90, 0); want_rsp("R12 store", 16'hD9D9);
    cpu_op(1, 8'h90, 16'hD9D9); dir(3'd3, 8'h90, 0); gap();
    load_hit("R12 touch", 8'h80, 16'h8888);
    load_hit("R12 touch", 8'h60, 16'h6666);
    load_hit("R12 touch", 8'hA0, 16'hAAAA);

    // R11 Modified victim
    want_msg("R11 victim writeback", 3'd6, 8'h90, 16'hD9D9);
    cpu_op(0, 8'hB0, 0);
    repeat (2) @(negedge clk);
    chk(msg_out_valid == 0, "R11 waits for done", {31'd0, msg_out_valid}, 0);
    want_msg("R11 read after done", 3'd1, 8'hB0, 0);
    dir(3'd5, 8'h90, 0);
    want_rsp("R11 fill", 16'hBBBB);
    dir(3'd1, 8'hB0, 16'hBBBB); gap();
    load_miss("R12 evicted line misses", 8'h70, 16'h7070);

    gap();
    chk(exp_msg.size() == 0, "R10 all messages seen", exp_msg.size(), 0);
    chk(exp_rsp.size() == 0, "R3 all responses seen", exp_rsp.size(), 0);
    summary();
  end
endmodule